// File: doc/BRIEF.md
# CAN Receive Mailbox

This block is one receive mailbox placed after a CAN frame receiver. Each completed frame (identifier, data length code and up to eight data bytes carried as two 32-bit words) arrives on a valid/ready stream. The mailbox compares the frame identifier with a programmed identifier under an acceptance mask. It keeps an accepted frame under one of two policies: hold the first message until software releases it, or always keep the newest message. It reports a ready flag, a message-lost flag and an interrupt request that an external enable gates.

Software reaches the mailbox through a small word-addressed register port. It programs the filter and mode, reads the stored frame and the status, and issues a transfer command when it is done with the data. The frame stream never applies back-pressure. `frm_ready` is high whenever reset is released, and a frame counts as delivered on any cycle where `frm_valid` and `frm_ready` are both high. The upstream receiver never has to wait, so a frame the mailbox cannot keep is dropped and the drop is reported, not stalled.

Top module: `can_rx_mailbox`

## Requirements
- R1: Mode field is CFG (address 0) bits [1:0]: 0 = off, 1 = keep-first, 2 = keep-latest, 3 = treated as off. While off, incoming frames are ignored and the ready and lost flags read 0.
- R2: A frame is accepted when ((frame id XOR filter id) AND filter mask) is zero. Mask bits at 0 are don't-care.
- R3: A write to CFG copies the ID (address 1) and MASK (address 2) registers into the active filter and clears ready and lost. ID/MASK writes made later do not change filtering until the next CFG write. A frame arriving in the same cycle as a CFG write is ignored.
- R4: A frame accepted while ready is 0 stores its identifier, length code, low word and high word together, and ready reads 1 from the next cycle.
- R5: In keep-first mode, a frame accepted while ready is 1 leaves the stored frame unchanged and sets the lost flag.
- R6: In keep-latest mode, a frame accepted while ready is 1 replaces the stored frame and sets the lost flag.
- R7: Writing 1 to CMD (address 7) bit 0 clears ready. A frame accepted in the same cycle is handled as if it arrived after the clear: it is stored, ready stays 1 and no loss is flagged.
- R8: A read strobe on STATUS (address 3) clears the lost flag on the next cycle. If a loss occurs in the same cycle, lost stays 1.
- R9: `irq` is high exactly while ready is 1 and `irq_en` is 1.
- R10: Reads are combinational. STATUS bit 0 is ready, bit 1 is lost, and bits [11:8] are the stored length code. DATA_LO (4) and DATA_HI (5) return the stored words, and RXID (6) returns the stored identifier zero-extended.
- R11: `frm_ready` is 1 while out of reset.
- R12: After reset, the flags, `irq`, the stored frame and the mode are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame present on the stream |
| frm_ready | output | 1 | Mailbox takes the frame (always 1 out of reset) |
| frm_id | input | ID_W | Frame identifier |
| frm_dlc | input | 4 | Frame data length code |
| frm_data_lo | input | 32 | Data bytes 0..3 |
| frm_data_hi | input | 32 | Data bytes 4..7 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq_en | input | 1 | This mailbox's bit of the global interrupt mask |
| irq | output | 1 | Mailbox interrupt request |
| mbx_ready | output | 1 | Ready flag |
| mbx_lost | output | 1 | Message-lost flag |

## Verification
The bench builds the mailbox with an 11-bit identifier (`ID_W = 11`) and the default 32-bit words. The short identifier makes mask patterns easy to reason about. It lets the bench place matching and non-matching frames that differ in a single bit, either inside or outside the don't-care nibble. The same build reaches every mode switch, the shadowed filter reload and the same-cycle collisions of a transfer command or status read with an arriving frame.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_KEEP = 2'd1,
    MODE_OVWR = 2'd2,
    MODE_RSVD = 2'd3
  } mbx_mode_e;

  localparam int ADDR_W = 3;
  localparam int REG_W  = 32;
  localparam int DLC_W  = 4;

  localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] A_ID     = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] A_DLO    = 3'd4;
  localparam logic [ADDR_W-1:0] A_DHI    = 3'd5;
  localparam logic [ADDR_W-1:0] A_RXID   = 3'd6;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd7;
endpackage

// File: rtl/can_mbx_filter.sv
module can_mbx_filter #(
  parameter int ID_W = 29
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] new_id,
  input  logic [ID_W-1:0] new_mask,
  input  logic [ID_W-1:0] frm_id,
  output logic            hit
);
  logic [ID_W-1:0] act_id;
  logic [ID_W-1:0] act_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_id   <= '0;
      act_mask <= '0;
    end else if (load) begin
      act_id   <= new_id;
      act_mask <= new_mask;
    end
  end

  assign hit = (((frm_id ^ act_id) & act_mask) == '0);
endmodule

// File: rtl/can_mbx_store.sv
module can_mbx_store #(
  parameter int ID_W   = 29,
  parameter int WORD_W = 32,
  parameter int DLC_W  = 4,
  parameter int NWORDS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [ID_W-1:0]          in_id,
  input  logic [DLC_W-1:0]         in_dlc,
  input  logic [NWORDS*WORD_W-1:0] in_data,
  output logic [ID_W-1:0]          st_id,
  output logic [DLC_W-1:0]         st_dlc,
  output logic [NWORDS*WORD_W-1:0] st_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_id  <= '0;
      st_dlc <= '0;
    end else if (en) begin
      st_id  <= in_id;
      st_dlc <= in_dlc;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_data[w*WORD_W +: WORD_W] <= '0;
      else if (en) st_data[w*WORD_W +: WORD_W] <= in_data[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/can_mbx_flags.sv
module can_mbx_flags
  import can_mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mbx_mode_e mode,
  input  logic      arm,
  input  logic      frm_take,
  input  logic      hit,
  input  logic      xfer,
  input  logic      stat_rd,
  output logic      acc,
  output logic      store_en,
  output logic      rdy,
  output logic      lost
);
  logic enabled;
  logic eff_rdy;
  logic loss;

  assign enabled  = (mode == MODE_KEEP) || (mode == MODE_OVWR);
  assign eff_rdy  = rdy & ~xfer;
  assign acc      = frm_take & hit & enabled & ~arm;
  assign loss     = acc & eff_rdy;
  assign store_en = acc & (~eff_rdy | (mode == MODE_OVWR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      lost <= 1'b0;
    end else if (arm || !enabled) begin
      rdy  <= 1'b0;
      lost <= 1'b0;
    end else begin
      rdy  <= eff_rdy | acc;
      lost <= loss | (lost & ~stat_rd);
    end
  end
endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
  import can_mbx_pkg::*;
#(
  parameter int ID_W   = 29,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [WORD_W-1:0] frm_data_lo,
  input  logic [WORD_W-1:0] frm_data_hi,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              irq_en,
  output logic              irq,
  output logic              mbx_ready,
  output logic              mbx_lost
);
  localparam int NWORDS = 2;
  localparam int DATA_W = NWORDS * WORD_W;

  mbx_mode_e          cfg_mode;
  logic [ID_W-1:0]    sh_id;
  logic [ID_W-1:0]    sh_mask;
  logic               arm, xfer_cmd, stat_rd, frm_take;
  logic               filt_hit, acc_hit, store_en;
  logic [ID_W-1:0]    st_id;
  logic [DLC_W-1:0]   st_dlc;
  logic [DATA_W-1:0]  st_data;
  logic [WORD_W-1:0]  st_lo, st_hi;

  assign arm      = reg_wr && (reg_addr == A_CFG);
  assign xfer_cmd = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];
  assign stat_rd  = reg_rd && (reg_addr == A_STATUS);
  assign frm_take = frm_valid && frm_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frm_ready <= 1'b0;
    else        frm_ready <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode <= MODE_OFF;
      sh_id    <= '0;
      sh_mask  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CFG:   cfg_mode <= mbx_mode_e'(reg_wdata[1:0]);
        A_ID:    sh_id    <= reg_wdata[ID_W-1:0];
        A_MASK:  sh_mask  <= reg_wdata[ID_W-1:0];
        default: ;
      endcase
    end
  end

  can_mbx_filter #(.ID_W(ID_W)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (arm),
    .new_id   (sh_id),
    .new_mask (sh_mask),
    .frm_id   (frm_id),
    .hit      (filt_hit)
  );

  can_mbx_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_mode),
    .arm      (arm),
    .frm_take (frm_take),
    .hit      (filt_hit),
    .xfer     (xfer_cmd),
    .stat_rd  (stat_rd),
    .acc      (acc_hit),
    .store_en (store_en),
    .rdy      (mbx_ready),
    .lost     (mbx_lost)
  );

  can_mbx_store #(.ID_W(ID_W), .WORD_W(WORD_W), .DLC_W(DLC_W), .NWORDS(NWORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (store_en),
    .in_id   (frm_id),
    .in_dlc  (frm_dlc),
    .in_data ({frm_data_hi, frm_data_lo}),
    .st_id   (st_id),
    .st_dlc  (st_dlc),
    .st_data (st_data)
  );

  assign st_lo = st_data[WORD_W-1:0];
  assign st_hi = st_data[DATA_W-1:WORD_W];
  assign irq   = mbx_ready & irq_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:    reg_rdata[1:0] = cfg_mode;
      A_ID:     reg_rdata[ID_W-1:0] = sh_id;
      A_MASK:   reg_rdata[ID_W-1:0] = sh_mask;
      A_STATUS: begin
        reg_rdata[0]    = mbx_ready;
        reg_rdata[1]    = mbx_lost;
        reg_rdata[11:8] = st_dlc;
      end
      A_DLO:    reg_rdata[WORD_W-1:0] = st_lo;
      A_DHI:    reg_rdata[WORD_W-1:0] = st_hi;
      A_RXID:   reg_rdata[ID_W-1:0] = st_id;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_rx_mailbox_chk.sv
module can_rx_mailbox_chk
  import can_mbx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input mbx_mode_e         mode,
  input logic              arm,
  input logic              acc,
  input logic              xfer,
  input logic              stat_rd,
  input logic              rdy,
  input logic              lost,
  input logic [WORD_W-1:0] st_lo
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF || mode == MODE_RSVD) |-> (!rdy && !lost));

  p_arm_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!rdy && !lost));

  p_accept_sets_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rdy);

  p_keep_first_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_KEEP && acc && rdy && !xfer) |=> ($stable(st_lo) && lost));

  p_overwrite_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OVWR && acc && rdy && !xfer) |=> lost);

  p_xfer_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !acc) |=> !rdy);

  p_stat_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !acc) |=> !lost);
endmodule

bind can_rx_mailbox can_rx_mailbox_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (cfg_mode),
  .arm     (arm),
  .acc     (acc_hit),
  .xfer    (xfer_cmd),
  .stat_rd (stat_rd),
  .rdy     (mbx_ready),
  .lost    (mbx_lost),
  .st_lo   (st_lo)
);

// File: tb/can_rx_mailbox_test.sv
module can_rx_mailbox_test;
  localparam int CLK_NS = 10;
  localparam int IDW    = 11;

  localparam logic [1:0] OP_FRM  = 2'd0;
  localparam logic [1:0] OP_STAT = 2'd1;
  localparam logic [1:0] OP_XFER = 2'd2;

  typedef struct packed {
    logic [1:0]     op;
    logic [IDW-1:0] id;
    logic [31:0]    lo;
    logic           e_rdy;
    logic           e_lost;
    logic [31:0]    e_lo;
  } vec_t;

  // filter id 0x123, mask 0x7F0, keep-first mode
  localparam vec_t TBL [6] = '{
    '{OP_FRM,  11'h125, 32'hA1A1_0001, 1'b1, 1'b0, 32'hA1A1_0001},  // R4 R2
    '{OP_FRM,  11'h129, 32'hB2B2_0002, 1'b1, 1'b1, 32'hA1A1_0001},  // R5
    '{OP_FRM,  11'h133, 32'hC3C3_0003, 1'b1, 1'b1, 32'hA1A1_0001},  // R2 reject
    '{OP_STAT, 11'h000, 32'h0,         1'b1, 1'b0, 32'hA1A1_0001},  // R8
    '{OP_XFER, 11'h000, 32'h0,         1'b0, 1'b0, 32'hA1A1_0001},  // R7
    '{OP_FRM,  11'h12F, 32'hD4D4_0004, 1'b1, 1'b0, 32'hD4D4_0004}   // R4
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frm_valid = 1'b0;
  logic           frm_ready;
  logic [IDW-1:0] frm_id = '0;
  logic [3:0]     frm_dlc = '0;
  logic [31:0]    frm_data_lo = '0;
  logic [31:0]    frm_data_hi = '0;
  logic           reg_wr = 1'b0;
  logic           reg_rd = 1'b0;
  logic [2:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           irq_en = 1'b0;
  logic           irq;
  logic           mbx_ready;
  logic           mbx_lost;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  can_rx_mailbox #(.ID_W(IDW), .WORD_W(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_id(frm_id), .frm_dlc(frm_dlc),
    .frm_data_lo(frm_data_lo), .frm_data_hi(frm_data_hi),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_en(irq_en), .irq(irq),
    .mbx_ready(mbx_ready), .mbx_lost(mbx_lost)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // one cycle: optional frame, optional transfer command, optional status read
  task automatic step(input bit fv, input logic [IDW-1:0] id, input logic [31:0] lo,
                      input bit xfer, input bit srd);
    @(negedge clk);
    frm_valid = fv; frm_id = id; frm_data_lo = lo; frm_data_hi = ~lo; frm_dlc = lo[3:0];
    if (xfer) begin reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 32'd1; end
    else if (srd) begin reg_rd = 1'b1; reg_addr = 3'd3; end
    @(negedge clk);
    frm_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 ready", {31'b0, mbx_ready}, 32'd0);
    check("R12 lost", {31'b0, mbx_lost}, 32'd0);
    check("R12 irq", {31'b0, irq}, 32'd0);
    peek(3'd4, v); check("R12 data_lo", v, 32'd0);
    peek(3'd0, v); check("R12 mode", v, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 frm_ready", {31'b0, frm_ready}, 32'd1);

    // R1 off: frames ignored
    wr(3'd1, 32'h123); wr(3'd2, 32'h7F0);
    step(1'b1, 11'h123, 32'h1111_1111, 1'b0, 1'b0);
    check("R1 off ignores frame", {30'b0, mbx_lost, mbx_ready}, 32'd0);
    wr(3'd0, 32'd3);
    step(1'b1, 11'h123, 32'h1111_1111, 1'b0, 1'b0);
    check("R1 mode3 ignores frame", {30'b0, mbx_lost, mbx_ready}, 32'd0);

    // table walk, keep-first mode
    wr(3'd0, 32'd1);
    for (int i = 0; i < 6; i++) begin
      step(TBL[i].op == OP_FRM, TBL[i].id, TBL[i].lo, TBL[i].op == OP_XFER, TBL[i].op == OP_STAT);
      check($sformatf("R4/R5/R7/R8/R2 vec%0d ready", i), {31'b0, mbx_ready}, {31'b0, TBL[i].e_rdy});
      check($sformatf("R5/R8 vec%0d lost", i), {31'b0, mbx_lost}, {31'b0, TBL[i].e_lost});
      peek(3'd4, v);
      check($sformatf("R10 vec%0d data_lo", i), v, TBL[i].e_lo);
    end
    // R4 atomic store of other fields
    peek(3'd5, v); check("R4 data_hi", v, ~32'hD4D4_0004);
    peek(3'd6, v); check("R4 rxid", v, 32'h12F);
    peek(3'd3, v); check("R10 status dlc", v, 32'h0000_0401);

    // R9 interrupt gating
    check("R9 irq masked", {31'b0, irq}, 32'd0);
    irq_en = 1'b1; #1;
    check("R9 irq enabled", {31'b0, irq}, 32'd1);

    // R7 same-cycle transfer and frame
    step(1'b1, 11'h120, 32'hE5E5_0005, 1'b1, 1'b0);
    check("R7 same-cycle ready", {31'b0, mbx_ready}, 32'd1);
    check("R7 same-cycle no loss", {31'b0, mbx_lost}, 32'd0);
    peek(3'd4, v); check("R7 same-cycle stored", v, 32'hE5E5_0005);

    // R8 loss and status read in same cycle
    step(1'b1, 11'h121, 32'hF6F6_0006, 1'b0, 1'b1);
    check("R8 loss wins", {31'b0, mbx_lost}, 32'd1);
    peek(3'd4, v); check("R5 keep-first held", v, 32'hE5E5_0005);

    // R3 re-arm clears flags; overwrite mode R6
    wr(3'd0, 32'd2);
    check("R3 arm clears", {30'b0, mbx_lost, mbx_ready}, 32'd0);
    check("R9 irq low after clear", {31'b0, irq}, 32'd0);
    step(1'b1, 11'h124, 32'h0707_0007, 1'b0, 1'b0);
    step(1'b1, 11'h12A, 32'h0808_0008, 1'b0, 1'b0);
    check("R6 lost set", {31'b0, mbx_lost}, 32'd1);
    peek(3'd4, v); check("R6 replaced lo", v, 32'h0808_0008);
    peek(3'd6, v); check("R6 replaced id", v, 32'h12A);

    // R3 shadow filter: new ID not active until re-arm
    wr(3'd1, 32'h200);
    step(1'b0, '0, '0, 1'b1, 1'b0);
    step(1'b1, 11'h123, 32'h0909_0009, 1'b0, 1'b0);
    check("R3 old filter still active", {31'b0, mbx_ready}, 32'd1);
    wr(3'd0, 32'd1);
    step(1'b1, 11'h123, 32'h0A0A_000A, 1'b0, 1'b0);
    check("R3 old id rejected after arm", {31'b0, mbx_ready}, 32'd0);
    step(1'b1, 11'h20C, 32'h0B0B_000B, 1'b0, 1'b0);
    check("R3 new id accepted", {31'b0, mbx_ready}, 32'd1);

    // R3 frame during CFG write is ignored
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'd1;
    frm_valid = 1'b1; frm_id = 11'h200; frm_data_lo = 32'h0C0C_000C;
    @(negedge clk);
    reg_wr = 1'b0; frm_valid = 1'b0;
    check("R3 frame with arm ignored", {31'b0, mbx_ready}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule